// File: doc/BRIEF.md
# Push-Pull PWM Steering Controller

This block produces the gate-drive timing for a push-pull converter. A free-running period counter opens every period with a blanking window. During that window both drive outputs are held low, and the window also sets the dead time. After the blanking window a single pulse is issued. Its length follows a digitised duty command. A steering flip-flop routes the pulse to output A or output B, so successive pulses land on opposite transformer halves and the core sees balanced volt-seconds.

A current-limit flag cuts a pulse short at once. A per-period latch then keeps the pulse from restarting before the next blanking window, however much the flag chatters. An active-high shutdown silences both outputs without touching the period timing. When shutdown is released, the outputs come back only at the next period boundary. The steering state moves only at that boundary, so the output that fired last is never fired again first.

Several instances can share one timing reference. The blanking window appears on a sync output. A sync input that stays high for a programmable number of consecutive clock cycles restarts the local period. The local period is meant to be set somewhat longer than the external one, so the external pulse always wins.

Top module: `ppwm_steer`

## Requirements
- R1: Outputs A and B are never high in the same cycle, and consecutive pulses always alternate between A and B, including periods where a pulse was cut short.
- R2: A period lasts PERIOD cycles, with no sync restart. Sync-out is high for the first BLANK cycles of every period, and both outputs are low whenever sync-out is high.
- R3: A pulse starts in the first cycle after blanking and stays high for min(duty, PERIOD-BLANK) cycles. A duty of 0 gives no pulse. A duty at or above PERIOD-BLANK gives a pulse that ends exactly where the next blanking window begins.
- R4: At most one pulse rises per period. Once a pulse has ended, it cannot restart before the next blanking window.
- R5: While the current-limit input is high, both outputs are low in that same cycle, and the pulse stays off for the rest of the period. A limit held high for a whole period gives zero width.
- R6: While shutdown is high, both outputs are low in that same cycle, and sync-out keeps its PERIOD-cycle rhythm. After release, no pulse is issued before the next period boundary.
- R7: The first pulse after shutdown is released goes to the output opposite the last pulse issued before or during shutdown.
- R8: A sync input high for SYNC_MIN consecutive cycles restarts the period, so blanking begins in the next cycle. A sync pulse shorter than SYNC_MIN cycles does not change the period.
- R9: Reset (synchronous, active high) leaves both outputs low, sync-out high and the counter at phase zero. The first pulse after reset goes to output A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | DUTY_W | Duty command in clock cycles of on-time |
| cur_lim | input | 1 | Current-limit flag; high ends the present pulse |
| shdn | input | 1 | Shutdown, active high |
| sync_in | input | 1 | External period restart, qualified by length |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |
| sync_out | output | 1 | Blanking window, for slaving other instances |

## Verification
The bench sweeps the duty command from zero through values just under, at and above the active window. A design with an off-by-one comparator would show up here as a pulse one cycle long or short, or as a pulse that runs into the blanking window. A single-cycle current-limit blip in the middle of a pulse shows whether the per-period latch holds. Without it, the pulse would rise a second time in the same period. Shutdown is asserted in the middle of a pulse, held over two full periods and released in the middle of a period. A steering flip-flop that toggled freely during shutdown, or that resumed at once on release, would fire the same output twice or fire inside the release period. Sync pulses one cycle shorter than the qualifying length, and exactly at that length, show whether the restart threshold is off by one.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Timing marks shared by every stage of the block.
    typedef struct packed {
        logic blank;   // inside the dead-time window at the start of a period
        logic wrap;    // last cycle of the period (natural or sync restart)
    } tick_t;

    function automatic side_e other_side(input side_e s);
        return (s == SIDE_A) ? SIDE_B : SIDE_A;
    endfunction

endpackage

// File: rtl/ppwm_timer.sv
module ppwm_timer
    import ppwm_pkg::*;
#(
    parameter int PERIOD   = 40,
    parameter int BLANK    = 4,
    parameter int SYNC_MIN = 3,
    localparam int CNT_W   = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    output tick_t            tick,
    output logic [CNT_W-1:0] phase
);

    logic [CNT_W-1:0] cnt;
    logic             sync_hit;
    logic             wrap;

    // Sync qualification: a restart needs SYNC_MIN consecutive high samples.
    generate
        if (SYNC_MIN <= 1) begin : g_sync_direct
            assign sync_hit = sync_in;
        end else begin : g_sync_count
            localparam int SW = $clog2(SYNC_MIN + 1);
            logic [SW-1:0] run;
            always_ff @(posedge clk) begin
                if (rst) begin
                    run <= '0;
                end else if (!sync_in) begin
                    run <= '0;
                end else if (run != SW'(SYNC_MIN)) begin
                    run <= run + SW'(1);
                end
            end
            assign sync_hit = sync_in && (run == SW'(SYNC_MIN - 1));
        end
    endgenerate

    assign wrap = sync_hit || (cnt == CNT_W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign tick.blank = (cnt < CNT_W'(BLANK));
    assign tick.wrap  = wrap;
    assign phase      = cnt;

endmodule

// File: rtl/ppwm_gate.sv
module ppwm_gate
    import ppwm_pkg::*;
#(
    parameter int PERIOD  = 40,
    parameter int BLANK   = 4,
    parameter int DUTY_W  = 8,
    localparam int CNT_W  = $clog2(PERIOD),
    localparam int CMP_W  = ((CNT_W > DUTY_W) ? CNT_W : DUTY_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  tick_t             tick,
    input  logic [CNT_W-1:0]  phase,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic              cur_lim,
    input  logic              shdn,
    input  logic              shdn_hold,
    output logic              fire
);

    logic [DUTY_W-1:0] duty_q;
    logic              ended;
    logic [CMP_W-1:0]  offset;
    logic              in_window;
    logic              want;

    // Cycles elapsed since the end of blanking.
    assign offset    = CMP_W'(phase - CNT_W'(BLANK));
    assign in_window = offset < CMP_W'(duty_q);

    assign want = !tick.blank && !shdn && !shdn_hold && !cur_lim && in_window;
    assign fire = want && !ended;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            ended  <= 1'b0;
        end else begin
            if (tick.blank) begin
                duty_q <= duty_cmd;
            end
            if (tick.wrap || tick.blank) begin
                ended <= 1'b0;
            end else if (!want) begin
                ended <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppwm_steer_ctl.sv
module ppwm_steer_ctl
    import ppwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tick_t tick,
    input  logic  shdn,
    input  logic  fire,
    output side_e side,
    output logic  shdn_hold
);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            side      <= SIDE_A;
            pending   <= 1'b0;
            shdn_hold <= 1'b0;
        end else begin
            if (shdn) begin
                shdn_hold <= 1'b1;
            end else if (tick.wrap) begin
                shdn_hold <= 1'b0;
            end

            if (tick.wrap && !shdn) begin
                if (pending || fire) begin
                    side <= other_side(side);
                end
                pending <= 1'b0;
            end else if (fire) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppwm_steer.sv
module ppwm_steer
    import ppwm_pkg::*;
#(
    parameter int PERIOD   = 40,
    parameter int BLANK    = 4,
    parameter int SYNC_MIN = 3,
    parameter int DUTY_W   = 8,
    localparam int CNT_W   = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic              cur_lim,
    input  logic              shdn,
    input  logic              sync_in,
    output logic              out_a,
    output logic              out_b,
    output logic              sync_out
);

    tick_t            tick;
    logic [CNT_W-1:0] phase;
    logic             fire;
    logic             shdn_hold;
    side_e            side;

    ppwm_timer #(
        .PERIOD  (PERIOD),
        .BLANK   (BLANK),
        .SYNC_MIN(SYNC_MIN)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .sync_in(sync_in),
        .tick   (tick),
        .phase  (phase)
    );

    ppwm_gate #(
        .PERIOD(PERIOD),
        .BLANK (BLANK),
        .DUTY_W(DUTY_W)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .phase    (phase),
        .duty_cmd (duty_cmd),
        .cur_lim  (cur_lim),
        .shdn     (shdn),
        .shdn_hold(shdn_hold),
        .fire     (fire)
    );

    ppwm_steer_ctl u_steer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .shdn     (shdn),
        .fire     (fire),
        .side     (side),
        .shdn_hold(shdn_hold)
    );

    assign out_a    = fire && (side == SIDE_A);
    assign out_b    = fire && (side == SIDE_B);
    assign sync_out = tick.blank;

endmodule

// File: rtl/ppwm_steer_chk.sv
module ppwm_steer_chk (
    input logic clk,
    input logic rst,
    input logic cur_lim,
    input logic shdn,
    input logic out_a,
    input logic out_b,
    input logic sync_out
);

    logic prev_a, prev_b, seen, last_b;
    logic rise_a, rise_b;

    assign rise_a = out_a && !prev_a;
    assign rise_b = out_b && !prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
            seen   <= 1'b0;
            last_b <= 1'b0;
        end else begin
            prev_a <= out_a;
            prev_b <= out_b;
            if (rise_a) begin
                seen   <= 1'b1;
                last_b <= 1'b0;
            end else if (rise_b) begin
                seen   <= 1'b1;
                last_b <= 1'b1;
            end
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b)); // R1
    AST_ALTERNATE_A: assert property (@(posedge clk) disable iff (rst)
        (seen && rise_a) |-> last_b); // R1
    AST_ALTERNATE_B: assert property (@(posedge clk) disable iff (rst)
        (seen && rise_b) |-> !last_b); // R7
    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (!out_a && !out_b)); // R2
    AST_START_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
        (rise_a || rise_b) |-> $past(sync_out)); // R4
    AST_LIMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cur_lim |-> (!out_a && !out_b)); // R5
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        shdn |-> (!out_a && !out_b)); // R6

endmodule

bind ppwm_steer ppwm_steer_chk u_chk (.*);

// File: tb/tb_ppwm_steer.sv
module tb_ppwm_steer;

    localparam int PERIOD   = 40;
    localparam int BLANK    = 4;
    localparam int SYNC_MIN = 3;
    localparam int DUTY_W   = 8;
    localparam int ACTIVE   = PERIOD - BLANK;

    localparam int VEC_N = 7;
    localparam int DUTY_V[VEC_N] = '{0, 1, 9, 35, 36, 37, 255};
    localparam int EXP_W [VEC_N] = '{0, 1, 9, 35, 36, 36, 36};

    localparam int ACT_NONE = 0, ACT_LIM = 1, ACT_SYNC = 2, ACT_SD_ON = 3, ACT_SD_OFF = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DUTY_W-1:0] duty_cmd = '0;
    logic              cur_lim = 1'b0;
    logic              shdn = 1'b0;
    logic              sync_in = 1'b0;
    logic              out_a, out_b, sync_out;

    int n_chk  = 0;
    int n_fail = 0;
    int last_side = -1;
    int g_wa, g_wb, g_ra, g_rb, g_len;

    always #4 clk = ~clk;

    ppwm_steer #(
        .PERIOD(PERIOD), .BLANK(BLANK), .SYNC_MIN(SYNC_MIN), .DUTY_W(DUTY_W)
    ) dut (
        .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .cur_lim(cur_lim),
        .shdn(shdn), .sync_in(sync_in),
        .out_a(out_a), .out_b(out_b), .sync_out(sync_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Entered at a negedge where sync_out has just risen; returns at the next such negedge.
    task automatic run_period(input int act_at, input int act_kind, input int act_len);
        logic pa, pb, ps;
        bit   first;
        g_wa = 0; g_wb = 0; g_ra = 0; g_rb = 0; g_len = 0;
        pa = 1'b0; pb = 1'b0; ps = 1'b0; first = 1'b1;
        while (g_len < 4 * PERIOD) begin
            if (!first && sync_out && !ps) break;
            first = 1'b0;
            g_wa += int'(out_a);
            g_wb += int'(out_b);
            g_ra += int'(out_a && !pa);
            g_rb += int'(out_b && !pb);
            pa = out_a; pb = out_b; ps = sync_out;
            if (g_len == act_at) begin
                case (act_kind)
                    ACT_LIM:    cur_lim = 1'b1;
                    ACT_SYNC:   sync_in = 1'b1;
                    ACT_SD_ON:  shdn    = 1'b1;
                    ACT_SD_OFF: shdn    = 1'b0;
                    default: ;
                endcase
            end
            if (g_len == act_at + act_len) begin
                if (act_kind == ACT_LIM)  cur_lim = 1'b0;
                if (act_kind == ACT_SYNC) sync_in = 1'b0;
            end
            g_len++;
            @(negedge clk);
        end
    endtask

    // Alternation and single-pulse checks on the period just measured.
    task automatic note_side(input string req);
        int side;
        if (g_wa + g_wb == 0) return;
        chk(g_ra + g_rb == 1, "R4", g_ra + g_rb, 1);
        side = (g_wa > 0) ? 0 : 1;
        if (last_side >= 0) chk(side != last_side, req, side, 1 - last_side);
        last_side = side;
    endtask

    task automatic check_width(input int exp_w, input string req);
        chk(g_wa + g_wb == exp_w, req, g_wa + g_wb, exp_w);
        note_side("R1");
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!out_a && !out_b, "R9", int'(out_a) + int'(out_b), 0);
        chk(sync_out == 1'b1, "R9", int'(sync_out), 1);
        rst = 1'b0;

        // Table walk: R3 widths, R1 alternation, R2 period length
        for (int i = 0; i < VEC_N; i++) begin
            duty_cmd = DUTY_V[i][DUTY_W-1:0];
            run_period(-1, ACT_NONE, 0);
            check_width(EXP_W[i], "R3");
            chk(g_len == PERIOD, "R2", g_len, PERIOD);
            if (i == 1) chk(g_wa == 1, "R9", g_wa, 1); // first pulse after reset on A
        end

        // R4 / R5: one-cycle limit blip mid-pulse, no restart
        duty_cmd = 8'd20;
        run_period(10, ACT_LIM, 1);
        check_width(7, "R5");
        // R5: limit held through a whole period
        run_period(0, ACT_LIM, 1000);
        cur_lim = 1'b0;
        chk(g_wa + g_wb == 0, "R5", g_wa + g_wb, 0);
        run_period(-1, ACT_NONE, 0);
        check_width(20, "R5");

        // R6 / R7: shutdown mid-pulse, held, released mid-period
        run_period(10, ACT_SD_ON, 0);
        check_width(7, "R6");
        for (int k = 0; k < 2; k++) begin
            run_period(-1, ACT_NONE, 0);
            chk(g_wa + g_wb == 0, "R6", g_wa + g_wb, 0);
            chk(g_len == PERIOD, "R6", g_len, PERIOD);
        end
        run_period(15, ACT_SD_OFF, 0);
        chk(g_wa + g_wb == 0, "R6", g_wa + g_wb, 0);
        run_period(-1, ACT_NONE, 0);
        chk(g_wa + g_wb == 20, "R7", g_wa + g_wb, 20);
        note_side("R7");

        // R8: qualified and short sync pulses
        run_period(20, ACT_SYNC, SYNC_MIN);
        sync_in = 1'b0;
        chk(g_len == 20 + SYNC_MIN, "R8", g_len, 20 + SYNC_MIN);
        note_side("R1");
        run_period(20, ACT_SYNC, SYNC_MIN - 1);
        chk(g_len == PERIOD, "R8", g_len, PERIOD);
        check_width(20, "R3");

        // R9: reset in mid-run brings steering back to A
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!out_a && !out_b && sync_out, "R9", int'(out_a) + int'(out_b), 0);
        rst = 1'b0;
        last_side = -1;
        run_period(-1, ACT_NONE, 0);
        chk(g_wa == 20 && g_wb == 0, "R9", g_wa, 20);
        note_side("R1");
        run_period(-1, ACT_NONE, 0);
        chk(g_wb == 20 && g_wa == 0, "R1", g_wb, 20);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule